// File: doc/BRIEF.md
# Nine-Bit Serial Transceiver with Address Attention

This block is a full-duplex serial transceiver whose characters carry a 9-bit word. Each character has a low start bit, the nine word bits sent least significant first, an optional parity bit, and one or two high stop bits. The ninth word bit is the address flag. A word with that bit set to 1 is an address. A word with that bit at 0 is data. Both directions pace their bits in one of two ways. The first is a 16x oversampling tick supplied from outside the block. The second is an external serial clock, which the block samples in its own clock domain. Even with the external clock, every character keeps its full framing.

The receiver places each accepted word in a single-entry buffer and holds it there until the host pulses a read strobe. Parity errors, framing errors and overruns are reported through status flags. In attention mode, data words are dropped without a trace. Only address words are buffered, and only they raise the interrupt, so a host can inspect each address and leave attention mode once it is selected. Generating the baud tick and matching addresses in software are left to the surrounding logic.

Top module: `nine_bit_uart`

## Requirements
- R1: The line idles high. A character is sent as a 0 start bit, then word bits 0 to 8 (bit 8 being the address flag), then the parity bit when `parity_en` is 1, then one high stop bit, or two when `two_stop` is 1. In tick mode the start bit appears on `txd` in the cycle after the load.
- R2: With `sync_mode` at 0, every transmitted bit lasts exactly 16 `tick_16x` pulses. `txd` changes only on a tick or a load.
- R3: With `sync_mode` at 1, `txd` changes only at a detected rising edge of `ext_sclk`. After a load, the first rising edge drives the start bit. The receiver samples `rxd` at each detected falling edge, and framing is unchanged.
- R4: The parity bit is the XOR of all nine word bits, inverted when `parity_odd` is 1. The result is even parity over word plus parity when `parity_odd` is 0 and odd parity when it is 1.
- R5: A received word is presented on `rx_data` with `rx_ready` at 1 until a one-cycle `rx_read` pulse clears `rx_ready` and `overrun`.
- R6: With `attn_mode` at 0, every received word is buffered and `irq` follows `rx_ready`.
- R7: With `attn_mode` at 1, a word whose bit 8 is 0 is discarded: `rx_ready`, `irq` and `rx_data` are left unchanged. A word whose bit 8 is 1 is buffered and raises `irq`.
- R8: If any stop bit is sampled low, `frame_err` is 1 while that word is buffered.
- R9: If the received parity bit disagrees with R4, `parity_err` is 1 while that word is buffered.
- R10: A word that completes while `rx_ready` is 1 and no read is strobed sets `overrun` and is discarded. The buffered word is kept.
- R11: `tx_ready` is 0 from the cycle after a load until the last stop bit ends. `tx_valid` and `tx_data` are ignored during that time.
- R12: After reset, `txd` and `tx_ready` are 1, and `rx_ready`, `irq`, `frame_err`, `parity_err` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_16x | input | 1 | Oversampling pulse, 16 per bit time |
| sync_mode | input | 1 | 1 = pace bits from ext_sclk edges |
| ext_sclk | input | 1 | External serial clock |
| parity_en | input | 1 | Add and check a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| two_stop | input | 1 | 1 = two stop bits |
| attn_mode | input | 1 | Buffer only words with bit 8 set |
| tx_valid | input | 1 | Word offered for transmission |
| tx_data | input | 9 | Word to send, bit 8 = address flag |
| tx_ready | output | 1 | Transmitter idle, accepts a load |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_read | input | 1 | Host has read the buffer |
| rx_data | output | 9 | Buffered received word |
| rx_ready | output | 1 | Buffer holds an unread word |
| frame_err | output | 1 | Buffered word had a low stop bit |
| parity_err | output | 1 | Buffered word failed parity |
| overrun | output | 1 | A word was lost to a full buffer |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default oversampling ratio of 16 and pulses `tick_16x` on every second clock. One bit time therefore spans 32 clocks, which tests the tick gating and keeps every frame to a few hundred cycles. The serial clock is run at one eighth of the block clock, so the edge detectors see long stable phases and the rise-to-fall spacing that the loopback character relies on is met. The default ratio also sets the mid-bit sampling point. That point lets the bench drive a stop bit low for only part of the bit and still observe a framing error without a spurious restart.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
    localparam int WORD_W    = 9;
    localparam int FRAME_MAX = 14;   // lead + start + 9 + parity + 2 stop

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2
    } rx_phase_e;

    function automatic logic par_of(input logic [WORD_W-1:0] w, input logic odd);
        return (^w) ^ odd;
    endfunction
endpackage

// File: rtl/uart9_tx.sv
module uart9_tx
    import uart9_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              sync_i,
    input  logic              rise_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              two_stop_i,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] data_i,
    output logic              ready_o,
    output logic              txd_o
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] TLAST = CW'(OVS - 1);

    typedef struct packed {
        logic                 busy;
        logic [FRAME_MAX-1:0] sh;
        logic [3:0]           bitn;
        logic [CW-1:0]        tcnt;
    } tx_st_t;

    tx_st_t q, d;
    logic load, step;
    logic [3:0] nbits;
    logic [FRAME_MAX-2:0] frame;

    always_comb begin
        d     = q;
        load  = valid_i && !q.busy;
        step  = sync_i ? rise_i : (tick_i && (q.tcnt == TLAST));
        nbits = 4'd11 + {3'd0, par_en_i} + {3'd0, two_stop_i} + {3'd0, sync_i};
        frame = {2'b11, (par_en_i ? par_of(data_i, par_odd_i) : 1'b1), data_i, 1'b0};
        if (load) begin
            d.busy = 1'b1;
            // external-clock mode holds one idle bit so the start bit leaves on a rising edge
            d.sh   = sync_i ? {frame, 1'b1} : {1'b1, frame};
            d.bitn = '0;
            d.tcnt = '0;
        end else if (q.busy) begin
            if (!sync_i && tick_i) begin
                d.tcnt = (q.tcnt == TLAST) ? '0 : q.tcnt + 1'b1;
            end
            if (step) begin
                if (q.bitn == nbits - 4'd1) begin
                    d.busy = 1'b0;
                end else begin
                    d.sh   = {1'b1, q.sh[FRAME_MAX-1:1]};
                    d.bitn = q.bitn + 4'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign txd_o   = q.busy ? q.sh[0] : 1'b1;
    assign ready_o = !q.busy;

    assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && load) |=> !txd_o);

    assert_tick_paced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && !tick_i && !load) |=> $stable(txd_o));

    assert_sync_rise_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && !rise_i && !load) |=> $stable(txd_o));

    assert_busy_after_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !ready_o);
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
    import uart9_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              sync_i,
    input  logic              fall_i,
    input  logic              rxd_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              two_stop_i,
    input  logic              attn_i,
    input  logic              read_i,
    output logic [WORD_W-1:0] data_o,
    output logic              ready_o,
    output logic              frame_err_o,
    output logic              par_err_o,
    output logic              overrun_o
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] TLAST = CW'(OVS - 1);
    localparam logic [CW-1:0] HCHK  = CW'(OVS / 2 - 2);

    typedef struct packed {
        rx_phase_e         ph;
        logic [CW-1:0]     tcnt;
        logic [3:0]        bitn;
        logic [WORD_W-1:0] shw;
        logic              perr;
        logic              ferr;
        logic [WORD_W-1:0] bdat;
        logic              rdy;
        logic              bferr;
        logic              bperr;
        logic              ovr;
    } rx_st_t;

    rx_st_t q, d;
    logic samp, done, accept;
    logic [3:0] last;

    always_comb begin
        d      = q;
        samp   = 1'b0;
        done   = 1'b0;
        accept = 1'b0;
        last   = 4'd9 + {3'd0, par_en_i} + {3'd0, two_stop_i};
        if (read_i) begin
            d.rdy = 1'b0;
            d.ovr = 1'b0;
        end
        case (q.ph)
            RX_IDLE: begin
                if (sync_i) begin
                    if (fall_i && !rxd_i) begin
                        d.ph = RX_BITS; d.bitn = '0; d.perr = 1'b0; d.ferr = 1'b0;
                    end
                end else if (tick_i && !rxd_i) begin
                    d.ph = RX_START; d.tcnt = '0;
                end
            end
            RX_START: begin
                if (sync_i) begin
                    d.ph = RX_IDLE;
                end else if (tick_i) begin
                    if (q.tcnt == HCHK) begin
                        if (rxd_i) d.ph = RX_IDLE;
                        else begin
                            d.ph = RX_BITS; d.tcnt = '0; d.bitn = '0;
                            d.perr = 1'b0; d.ferr = 1'b0;
                        end
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            RX_BITS: begin
                if (sync_i) begin
                    samp = fall_i;
                end else if (tick_i) begin
                    samp   = (q.tcnt == TLAST);
                    d.tcnt = samp ? '0 : q.tcnt + 1'b1;
                end
                if (samp) begin
                    if (q.bitn < 4'd9)                          d.shw  = {rxd_i, q.shw[WORD_W-1:1]};
                    else if (par_en_i && (q.bitn == 4'd9))      d.perr = par_of(q.shw, par_odd_i) ^ rxd_i;
                    else if (!rxd_i)                            d.ferr = 1'b1;
                    d.bitn = q.bitn + 4'd1;
                    if (q.bitn == last) begin
                        done = 1'b1;
                        d.ph = RX_IDLE;
                    end
                end
            end
            default: d.ph = RX_IDLE;
        endcase
        if (done) begin
            accept = !attn_i || q.shw[WORD_W-1];
            if (accept) begin
                if (q.rdy && !read_i) begin
                    d.ovr = 1'b1;
                end else begin
                    d.bdat  = q.shw;
                    d.rdy   = 1'b1;
                    d.bferr = d.ferr;
                    d.bperr = d.perr;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_o      = q.bdat;
    assign ready_o     = q.rdy;
    assign frame_err_o = q.rdy & q.bferr;
    assign par_err_o   = q.rdy & q.bperr;
    assign overrun_o   = q.ovr;

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (read_i && !done) |=> (!ready_o && !overrun_o));

    assert_attn_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && attn_i && !q.shw[WORD_W-1] && !read_i) |=> ($stable(data_o) && $stable(ready_o)));

    assert_overrun_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && accept && q.rdy && !read_i) |=> (overrun_o && $stable(data_o)));
endmodule

// File: rtl/nine_bit_uart.sv
module nine_bit_uart
    import uart9_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_16x,
    input  logic              sync_mode,
    input  logic              ext_sclk,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              two_stop,
    input  logic              attn_mode,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              txd,
    input  logic              rxd,
    input  logic              rx_read,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              frame_err,
    output logic              parity_err,
    output logic              overrun,
    output logic              irq
);
    logic sclk_d, sclk_q;
    logic sclk_rise, sclk_fall;

    always_comb begin
        sclk_d    = ext_sclk;
        sclk_rise = ext_sclk & ~sclk_q;
        sclk_fall = ~ext_sclk & sclk_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_d;
    end

    uart9_tx #(.OVS(OVS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_16x),
        .sync_i     (sync_mode),
        .rise_i     (sclk_rise),
        .par_en_i   (parity_en),
        .par_odd_i  (parity_odd),
        .two_stop_i (two_stop),
        .valid_i    (tx_valid),
        .data_i     (tx_data),
        .ready_o    (tx_ready),
        .txd_o      (txd)
    );

    uart9_rx #(.OVS(OVS)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_16x),
        .sync_i      (sync_mode),
        .fall_i      (sclk_fall),
        .rxd_i       (rxd),
        .par_en_i    (parity_en),
        .par_odd_i   (parity_odd),
        .two_stop_i  (two_stop),
        .attn_i      (attn_mode),
        .read_i      (rx_read),
        .data_o      (rx_data),
        .ready_o     (rx_ready),
        .frame_err_o (frame_err),
        .par_err_o   (parity_err),
        .overrun_o   (overrun)
    );

    assign irq = rx_ready;

    assert_irq_addr_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (attn_mode && $rose(irq)) |-> rx_data[WORD_W-1]);

    assert_irq_follows_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!attn_mode && $rose(rx_ready)) |-> irq);
endmodule

// File: tb/nine_bit_uart_bench.sv
`timescale 1ns/1ps
module nine_bit_uart_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_16x = 1'b0;
    logic       sync_mode, ext_sclk = 1'b0, parity_en, parity_odd, two_stop, attn_mode;
    logic       tx_valid;
    logic [8:0] tx_data;
    logic       tx_ready, txd, rxd, rx_read;
    logic [8:0] rx_data;
    logic       rx_ready, frame_err, parity_err, overrun, irq;
    logic       loop_en, drv_rxd, sclk_run;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign rxd = loop_en ? txd : drv_rxd;

    nine_bit_uart u_nine_bit_uart (
        .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .sync_mode(sync_mode),
        .ext_sclk(ext_sclk), .parity_en(parity_en), .parity_odd(parity_odd),
        .two_stop(two_stop), .attn_mode(attn_mode), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
        .rx_read(rx_read), .rx_data(rx_data), .rx_ready(rx_ready),
        .frame_err(frame_err), .parity_err(parity_err), .overrun(overrun), .irq(irq)
    );

    // stimulus clocks: tick every second cycle, serial clock period of 8 cycles
    int cyc = 0;
    int scnt = 0;
    always @(negedge clk) begin
        cyc++;
        tick_16x <= (cyc % 2 == 0);
        if (sclk_run) begin
            scnt++;
            if (scnt == 4) begin ext_sclk <= ~ext_sclk; scnt = 0; end
        end else begin
            ext_sclk <= 1'b0; scnt = 0;
        end
    end

    // transmit reference model: bit queue advanced by ticks or serial-clock rises
    bit m_busy;
    bit m_q[$];
    int m_ticks;
    bit m_prev;
    bit m_rise, m_adv;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_q.delete(); m_ticks = 0; m_prev = 0;
        end else begin
            m_rise = ext_sclk && !m_prev;
            m_prev = ext_sclk;
            if (!m_busy) begin
                if (tx_valid) begin
                    if (sync_mode) m_q.push_back(1'b1);
                    m_q.push_back(1'b0);
                    for (int i = 0; i < 9; i++) m_q.push_back(tx_data[i]);
                    if (parity_en) m_q.push_back((^tx_data) ^ parity_odd);
                    m_q.push_back(1'b1);
                    if (two_stop) m_q.push_back(1'b1);
                    m_busy = 1; m_ticks = 0;
                end
            end else begin
                m_adv = 0;
                if (sync_mode) m_adv = m_rise;
                else if (tick_16x) begin
                    m_ticks++;
                    if (m_ticks == 16) begin m_adv = 1; m_ticks = 0; end
                end
                if (m_adv) begin
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) m_busy = 0;
                end
            end
        end
    end

    bit exp_txd;
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            exp_txd = (m_busy && m_q.size() > 0) ? m_q[0] : 1'b1;
            checks++;
            if (txd !== exp_txd || tx_ready !== !m_busy) begin
                errors++;
                $display("FAIL R1/R2/R3/R4/R11 txd=%0b tx_ready=%0b expected txd=%0b tx_ready=%0b",
                         txd, tx_ready, exp_txd, !m_busy);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // receive expectation
    bit       e_ready, e_ferr, e_perr, e_ovr;
    bit [8:0] e_data;

    task automatic rx_expect(input bit [8:0] w, input bit pbad, input bit fbad);
        if (attn_mode && !w[8]) return;
        if (e_ready) e_ovr = 1;
        else begin e_ready = 1; e_data = w; e_perr = pbad; e_ferr = fbad; end
    endtask

    task automatic check_rx(input string req);
        chk({req, " rx_ready"}, rx_ready, e_ready);
        chk({req, " irq"}, irq, e_ready);
        if (e_ready) chk({req, " rx_data"}, rx_data, e_data);
        chk({req, " frame_err"}, frame_err, e_ready & e_ferr);
        chk({req, " parity_err"}, parity_err, e_ready & e_perr);
        chk({req, " overrun"}, overrun, e_ovr);
    endtask

    task automatic do_read();
        rx_read = 1;
        @(negedge clk);
        rx_read = 0;
        e_ready = 0; e_ovr = 0;
        @(negedge clk);
        check_rx("R5 after read");
    endtask

    task automatic drive_bit(input bit b, input int n);
        drv_rxd = b;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_rx(input bit [8:0] w, input bit pbad, input bit fbad);
        drive_bit(1'b0, 32);
        for (int i = 0; i < 9; i++) drive_bit(w[i], 32);
        if (parity_en) drive_bit((^w) ^ parity_odd ^ pbad, 32);
        for (int s = 0; s < 1 + two_stop; s++) begin
            if (fbad && s == two_stop) begin drive_bit(1'b0, 18); drive_bit(1'b1, 14); end
            else drive_bit(1'b1, 32);
        end
        drive_bit(1'b1, 32);
        rx_expect(w, pbad, fbad);
    endtask

    task automatic send_tx(input bit [8:0] w);
        tx_valid = 1; tx_data = w;
        @(negedge clk);
        chk("R11 busy after load", tx_ready, 0);
        tx_data = ~w;                      // R11: changed word while busy must be ignored
        repeat (40) @(negedge clk);
        tx_valid = 0;
        while (!tx_ready) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        rst_n = 0; sync_mode = 0; parity_en = 0; parity_odd = 0; two_stop = 0;
        attn_mode = 0; tx_valid = 0; tx_data = '0; rx_read = 0; loop_en = 0;
        drv_rxd = 1; sclk_run = 0;
        e_ready = 0; e_ferr = 0; e_perr = 0; e_ovr = 0; e_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R12 txd", txd, 1);
        chk("R12 tx_ready", tx_ready, 1);
        check_rx("R12");

        // transmit, tick paced (R1, R2, R4, R11)
        parity_en = 1; parity_odd = 0; two_stop = 0;
        send_tx(9'h1A5);
        parity_odd = 1; two_stop = 1;
        send_tx(9'h0FF);
        parity_en = 0; two_stop = 0;
        send_tx(9'h100);

        // receive basics (R5, R6)
        send_rx(9'h0A5, 0, 0);
        check_rx("R5 R6 word");
        do_read();

        // parity (R9)
        parity_en = 1; parity_odd = 0;
        send_rx(9'h13C, 0, 0);
        check_rx("R9 good parity");
        do_read();
        send_rx(9'h13C, 1, 0);
        check_rx("R9 bad parity");
        do_read();
        parity_odd = 1;
        send_rx(9'h0F1, 1, 0);
        check_rx("R9 bad odd parity");
        do_read();
        parity_en = 0;

        // framing (R8)
        two_stop = 1;
        send_rx(9'h055, 0, 1);
        check_rx("R8 low stop");
        do_read();
        two_stop = 0;

        // overrun (R10)
        send_rx(9'h011, 0, 0);
        send_rx(9'h022, 0, 0);
        check_rx("R10 overrun");
        do_read();

        // attention (R7)
        attn_mode = 1;
        send_rx(9'h033, 0, 0);
        check_rx("R7 data dropped");
        send_rx(9'h1C3, 0, 0);
        check_rx("R7 address kept");
        do_read();
        attn_mode = 0;

        // external clock loopback (R3)
        sync_mode = 1; loop_en = 1; sclk_run = 1;
        parity_en = 1; parity_odd = 1; two_stop = 1;
        send_tx(9'h16B);
        repeat (16) @(negedge clk);
        rx_expect(9'h16B, 0, 0);
        check_rx("R3 loopback");
        do_read();
        sclk_run = 0;
        repeat (4) @(negedge clk);
        sync_mode = 0; loop_en = 0;
        repeat (4) @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule